// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared memory that two independent ports reach at the same time. Each port presents an address, an active-low enable and an active-low write strobe. When both ports are enabled on the same address, the block picks one of them to hold off. It drives an active-low busy flag to the port that reached that address later. It also stops that port's write from reaching the memory, so the port that arrived first keeps clean access.

Arrival order is tracked on the clock. Each cycle the block compares every port's enable and address with the value it registered one cycle earlier. A port whose value changed in the current cycle is treated as the newcomer. If both ports change in the same cycle, a fixed rule applies: the left port wins. A mode input picks one of two roles. In master mode the block arbitrates and drives both busy flags. In slave mode both busy flags come in from outside, and each one only blocks writes on its own port.

Top module: `dual_port_collision_arbiter`

## Requirements
- R1: While reset is asserted and right after it, both busy outputs read 1 (inactive).
- R2: When the two addresses differed in a cycle, both busy outputs read 1 in the following cycle (master mode).
- R3: When either enable was 1 (inactive) in a cycle, both busy outputs read 1 in the following cycle, even if the addresses match (master mode).
- R4: On a collision (both enables 0, same address), the port whose enable or address changed in that cycle while the other's did not loses. The loser's busy output reads 0 from the next cycle on and the other port's busy stays 1. An unchanged collision keeps the same loser.
- R5: The two busy outputs are never 0 in the same cycle.
- R6: If both ports change in the same cycle into a collision, the right port loses and the left port wins.
- R7: In master mode a port's write output is 0 in any cycle in which it is the collision loser or its busy output reads 0. The busy inputs have no effect in master mode.
- R8: Busy is released one cycle after the collision ends. In the first non-colliding cycle the loser's busy output still reads 0, and in the cycle after that it reads 1.
- R9: In slave mode (masterMode = 0) both busy outputs read 1. A busy input at 0 forces only that port's write output to 0.
- R10: A write output is 1 (active high) only when its port's enable is 0, its write strobe is 0 and the port is not blocked. It responds in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = block arbitrates and drives busy, 0 = busy comes from inputs |
| leftCeN | input | 1 | Left port enable, active low |
| leftAddr | input | ADDR_W | Left port address |
| leftWeN | input | 1 | Left port write strobe, active low |
| rightCeN | input | 1 | Right port enable, active low |
| rightAddr | input | ADDR_W | Right port address |
| rightWeN | input | 1 | Right port write strobe, active low |
| busyInLeftN | input | 1 | External busy for the left port, used in slave mode |
| busyInRightN | input | 1 | External busy for the right port, used in slave mode |
| busyLeftN | output | 1 | Busy flag to the left port, active low |
| busyRightN | output | 1 | Busy flag to the right port, active low |
| leftWrite | output | 1 | Gated write enable to the memory for the left port |
| rightWrite | output | 1 | Gated write enable to the memory for the right port |

## Verification
The bench builds collisions where each port in turn arrives second. A design with the order reversed would flag the port that was already working. It also drives a same-cycle arrival, where a design without the fixed preference would flag neither port or both. It checks the loser's write in the very first collision cycle, where a design that gated only on the registered flag would let the write reach the memory. It checks the cycle just after the collision ends, where a design that released early or held busy too long would show the wrong level. Slave-mode steps, and master-mode steps with the busy inputs pulled low, catch a mode multiplexer that is wired backwards.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic blockLeft;
    logic blockRight;
    logic busyLeftN;
    logic busyRightN;
  } arbStrobes_t;

  localparam int NUM_PORTS = 2;
  localparam int PORT_LEFT = 0;
  localparam int PORT_RIGHT = 1;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftCeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWeN,
  input  logic              rightCeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWeN,
  input  arbStrobes_t       strobes,
  output logic              collide,
  output logic              chgLeft,
  output logic              chgRight,
  output logic              leftWrite,
  output logic              rightWrite
);
  localparam int TAG_W = ADDR_W + 1;

  logic [TAG_W-1:0] curTag  [NUM_PORTS];
  logic [TAG_W-1:0] prevTag [NUM_PORTS];
  logic [NUM_PORTS-1:0] changed;
  logic [NUM_PORTS-1:0] portCeN;
  logic [NUM_PORTS-1:0] portWeN;
  logic [NUM_PORTS-1:0] portBlock;
  logic [NUM_PORTS-1:0] portWrite;

  assign curTag[PORT_LEFT]  = {leftCeN, leftAddr};
  assign curTag[PORT_RIGHT] = {rightCeN, rightAddr};
  assign portCeN   = {rightCeN, leftCeN};
  assign portWeN   = {rightWeN, leftWeN};
  assign portBlock = {strobes.blockRight, strobes.blockLeft};

  // per-port change detector and write gate
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevTag[g] <= {1'b1, {ADDR_W{1'b0}}};
      end else begin
        prevTag[g] <= curTag[g];
      end
    end
    assign changed[g]   = (curTag[g] != prevTag[g]);
    assign portWrite[g] = ~portCeN[g] & ~portWeN[g] & ~portBlock[g];
  end

  assign collide    = ~leftCeN & ~rightCeN & (leftAddr == rightAddr);
  assign chgLeft    = changed[PORT_LEFT];
  assign chgRight   = changed[PORT_RIGHT];
  assign leftWrite  = portWrite[PORT_LEFT];
  assign rightWrite = portWrite[PORT_RIGHT];
endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        masterMode,
  input  logic        busyInLeftN,
  input  logic        busyInRightN,
  input  logic        collide,
  input  logic        chgLeft,
  input  logic        chgRight,
  output arbStrobes_t strobes
);
  logic heldLoserLeft;
  logic loserLeft;
  logic loseNowLeft;
  logic loseNowRight;
  logic busyLeftReg;
  logic busyRightReg;

  // arrival order: the port that changed this cycle is the newcomer
  always_comb begin
    if (chgLeft && !chgRight) begin
      loserLeft = 1'b1;
    end else if (chgRight) begin
      loserLeft = 1'b0;   // right alone, or tie: left wins
    end else begin
      loserLeft = heldLoserLeft;
    end
  end

  assign loseNowLeft  = collide & loserLeft;
  assign loseNowRight = collide & ~loserLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldLoserLeft <= 1'b0;
      busyLeftReg   <= 1'b0;
      busyRightReg  <= 1'b0;
    end else begin
      if (collide) begin
        heldLoserLeft <= loserLeft;
      end
      busyLeftReg  <= loseNowLeft;
      busyRightReg <= loseNowRight;
    end
  end

  always_comb begin
    if (masterMode) begin
      strobes.busyLeftN  = ~busyLeftReg;
      strobes.busyRightN = ~busyRightReg;
      strobes.blockLeft  = busyLeftReg | loseNowLeft;
      strobes.blockRight = busyRightReg | loseNowRight;
    end else begin
      strobes.busyLeftN  = 1'b1;
      strobes.busyRightN = 1'b1;
      strobes.blockLeft  = ~busyInLeftN;
      strobes.blockRight = ~busyInRightN;
    end
  end
endmodule

// File: rtl/dual_port_collision_arbiter.sv
module dual_port_collision_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftCeN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWeN,
  input  logic              rightCeN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWeN,
  input  logic              busyInLeftN,
  input  logic              busyInRightN,
  output logic              busyLeftN,
  output logic              busyRightN,
  output logic              leftWrite,
  output logic              rightWrite
);
  arbStrobes_t strobes;
  logic collide;
  logic chgLeft;
  logic chgRight;

  arb_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rstN(rstN),
    .leftCeN(leftCeN), .leftAddr(leftAddr), .leftWeN(leftWeN),
    .rightCeN(rightCeN), .rightAddr(rightAddr), .rightWeN(rightWeN),
    .strobes(strobes), .collide(collide),
    .chgLeft(chgLeft), .chgRight(chgRight),
    .leftWrite(leftWrite), .rightWrite(rightWrite)
  );

  arb_control u_control (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
    .collide(collide), .chgLeft(chgLeft), .chgRight(chgRight),
    .strobes(strobes)
  );

  assign busyLeftN  = strobes.busyLeftN;
  assign busyRightN = strobes.busyRightN;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              leftCeN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              rightCeN,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              busyInLeftN,
  input logic              busyInRightN,
  input logic              busyLeftN,
  input logic              busyRightN,
  input logic              leftWrite,
  input logic              rightWrite
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (busyLeftN && busyRightN));

  assert_addr_differ_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && (leftAddr != rightAddr)) |=> (busyLeftN && busyRightN));

  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && (leftCeN || rightCeN)) |=> (busyLeftN && busyRightN));

  assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyLeftN && !busyRightN));

  assert_left_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busyLeftN) |-> !leftWrite);

  assert_right_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busyRightN) |-> !rightWrite);

  assert_slave_left_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !busyInLeftN) |-> !leftWrite);

  assert_slave_right_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !busyInRightN) |-> !rightWrite);
endmodule

bind dual_port_collision_arbiter arb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .leftCeN(leftCeN), .leftAddr(leftAddr),
  .rightCeN(rightCeN), .rightAddr(rightAddr),
  .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
  .busyLeftN(busyLeftN), .busyRightN(busyRightN),
  .leftWrite(leftWrite), .rightWrite(rightWrite)
);

// File: tb/dual_port_collision_arbiter_tb.sv
module dual_port_collision_arbiter_tb;
  localparam int ADDR_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic leftCeN = 1'b1, rightCeN = 1'b1;
  logic leftWeN = 1'b1, rightWeN = 1'b1;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic busyInLeftN = 1'b1, busyInRightN = 1'b1;
  logic busyLeftN, busyRightN, leftWrite, rightWrite;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  wrL;
    logic  wrR;
    logic  bsyL;
    logic  bsyR;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  dual_port_collision_arbiter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftCeN(leftCeN), .leftAddr(leftAddr), .leftWeN(leftWeN),
    .rightCeN(rightCeN), .rightAddr(rightAddr), .rightWeN(rightWeN),
    .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
    .busyLeftN(busyLeftN), .busyRightN(busyRightN),
    .leftWrite(leftWrite), .rightWrite(rightWrite)
  );

  task automatic compare(input expItem_t e);
    testsRun++;
    if ({leftWrite, rightWrite, busyLeftN, busyRightN} !== {e.wrL, e.wrR, e.bsyL, e.bsyR}) begin
      testsFailed++;
      $display("FAIL %s: wrL/wrR/busyL/busyR actual %b%b%b%b expected %b%b%b%b",
               e.tag, leftWrite, rightWrite, busyLeftN, busyRightN,
               e.wrL, e.wrR, e.bsyL, e.bsyR);
    end
  endtask

  // driver: apply one cycle of stimulus and queue what the pins must show in that cycle
  task automatic step(input logic m, input logic cl, input int al, input logic wl,
                      input logic cr, input int ar, input logic wr,
                      input logic bl, input logic br,
                      input logic eWL, input logic eWR, input logic eBL, input logic eBR,
                      input string tag);
    expItem_t e;
    @(negedge clk);
    masterMode = m;
    leftCeN = cl; leftAddr = ADDR_W'(al); leftWeN = wl;
    rightCeN = cr; rightAddr = ADDR_W'(ar); rightWeN = wr;
    busyInLeftN = bl; busyInRightN = br;
    e.wrL = eWL; e.wrR = eWR; e.bsyL = eBL; e.bsyR = eBR; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: sample mid-cycle, away from the edges
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(negedge clk);
    #3;
    r.wrL = 1'b0; r.wrR = 1'b0; r.bsyL = 1'b1; r.bsyR = 1'b1; r.tag = "R1 during reset";
    compare(r);
    @(negedge clk);
    rstN = 1'b1;
    //   m cl  al wl cr  ar wr bl br   wL wR bL bR
    step(1, 1,  5, 0, 1,  5, 0, 1, 1,  0, 0, 1, 1, "R1 R3 after reset, both disabled");
    step(1, 0,  5, 0, 1,  5, 0, 1, 1,  1, 0, 1, 1, "R3 R10 left alone writes");
    step(1, 0,  5, 0, 0,  5, 0, 0, 1,  1, 0, 1, 1, "R4 R7 right arrives later, gated at once, busy inputs ignored");
    step(1, 0,  5, 0, 0,  5, 0, 1, 1,  1, 0, 1, 0, "R4 right busy held");
    step(1, 0,  5, 0, 0,  6, 0, 1, 1,  1, 0, 1, 0, "R8 R2 busy still low first free cycle");
    step(1, 0,  5, 1, 0,  6, 0, 1, 1,  0, 1, 1, 1, "R8 R10 busy released, left strobe high");
    step(1, 0,  9, 0, 0,  9, 0, 1, 1,  1, 0, 1, 1, "R6 tie, right loses");
    step(1, 0,  9, 0, 0,  9, 0, 1, 1,  1, 0, 1, 0, "R6 R5 right busy only");
    step(1, 0,  9, 0, 1,  9, 0, 1, 1,  1, 0, 1, 0, "R8 R3 right disabled");
    step(1, 0,  9, 0, 0, 20, 0, 1, 1,  1, 1, 1, 1, "R2 different addresses");
    step(1, 0, 20, 0, 0, 20, 0, 1, 1,  0, 1, 1, 1, "R4 R7 left arrives later");
    step(1, 0, 20, 0, 0, 20, 0, 1, 1,  0, 1, 0, 1, "R4 R5 left busy only");
    step(1, 1, 20, 0, 0, 20, 0, 1, 1,  0, 1, 0, 1, "R8 R3 left disabled, busy still low");
    step(1, 1, 20, 0, 0, 20, 0, 1, 1,  0, 1, 1, 1, "R3 match but left disabled");
    step(0, 0,  3, 0, 0,  3, 0, 1, 1,  1, 1, 1, 1, "R9 slave collision no block");
    step(0, 0,  3, 0, 0,  3, 0, 0, 1,  0, 1, 1, 1, "R9 slave left busy input");
    step(0, 0,  3, 0, 0,  3, 0, 1, 0,  1, 0, 1, 1, "R9 slave right busy input");
    step(1, 0,  3, 0, 0,  3, 0, 1, 1,  1, 0, 1, 0, "R4 held loser on return to master");
    step(1, 1,  3, 1, 1,  3, 1, 1, 1,  0, 0, 1, 0, "R10 R8 idle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule